// File: doc/BRIEF.md
# Bus Device Transfer Handshake Sequencer

This block paces a single transfer between one selected bus device and a central processor. It uses a four-phase handshake. The device first acknowledges its selection. The sequencer then raises a service request and waits. Next, the device drives its device number and pulls its strobe low. The sequencer then tells the processor that the device number is on the bus. While the device holds its done line low, the sequencer shows that the device is online. When the device lets go of the strobe, the sequencer drops back to idle and the strobe-phase timer is cleared.

All three device lines are active low and may change at any time. Each one passes through a synchronizer chain of `SYNC_STAGES` flops. Every output comes straight from a flop, so no output can glitch. A quit timer bounds the strobe phase. If the strobe is still held after `QUIT_CYCLES` clocks in that phase, a one-cycle timeout pulse is issued and the sequencer goes back to idle. A new transfer starts only on a fresh falling edge of the acknowledge seen in idle. An acknowledge that is left low, or that toggles while a transfer is in progress, therefore starts nothing.

Top module: `dev_xfer_sequencer`

## Requirements
- R1: Each of `sel_ack_n`, `num_strobe_n` and `xfer_done_n` passes through `SYNC_STAGES` flops, and the outputs are registered. A change on an input, driven between clock edges, first shows on an output after exactly `SYNC_STAGES`+1 rising edges.
- R2: In idle, a falling edge of `sel_ack_n` moves the sequencer to the request phase. `svc_req` is 1 throughout that phase and 0 in every other phase.
- R3: In the request phase, `num_strobe_n` low moves the sequencer to the strobe phase. `devnum_valid` is 1 throughout the strobe phase and 0 elsewhere. At most one of `svc_req`, `devnum_valid` and `quit_timeout` is 1 at a time.
- R4: `online` is 1 exactly when the sequencer is in the strobe phase and the synchronized `xfer_done_n` is low. `online` falls when `xfer_done_n` returns high. `xfer_done_n` has no effect outside the strobe phase.
- R5: `num_strobe_n` returning high during the strobe phase returns the sequencer to idle with all outputs 0. The quit timer is cleared, so the next strobe phase again gets the full `QUIT_CYCLES` window.
- R6: If the strobe is still held, the strobe phase lasts exactly `QUIT_CYCLES` clocks. `quit_timeout` is then 1 for exactly one clock, in the first idle clock, and all other outputs are 0. A strobe release seen in the last clock of the window wins, and no timeout is issued.
- R7: `sel_ack_n` returning high in the request phase, before any strobe, returns the sequencer to idle without entering the strobe phase.
- R8: The following never start or alter a transfer:
  - a falling edge of `sel_ack_n` outside idle;
  - `sel_ack_n` held low across the return to idle;
  - `num_strobe_n` low while idle.
- R9: While `rst_n` is low, the sequencer is idle and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_ack_n | input | 1 | Device select acknowledge, active low |
| num_strobe_n | input | 1 | Device-number strobe, active low |
| xfer_done_n | input | 1 | Transfer complete from device, active low |
| svc_req | output | 1 | Service request while waiting for the strobe |
| devnum_valid | output | 1 | Device number is on the bus (strobe phase) |
| online | output | 1 | Device online: strobe phase with done low |
| quit_timeout | output | 1 | One-clock pulse when the strobe phase times out |

## Verification
The bench builds the block with `SYNC_STAGES` = 2 and `QUIT_CYCLES` = 16, instead of the default window of 1024. The short window lets several complete timeouts run in a short test, including the exact-length strobe phase and the case where release and expiry land on the same clock. With only two synchronizer stages, the bench can aim an input change at one specific decision edge, so it can hit the one-cycle boundary between release and timeout precisely.

// File: rtl/dev_xfer_pkg.sv
package dev_xfer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_XFER = 2'd2
  } phase_e;

  typedef struct packed {
    logic svc;
    logic dnum;
    logic onl;
    logic quit;
  } seq_out_t;

  // Output image for the phase about to be entered.
  function automatic seq_out_t outputs_for(phase_e nxt, logic done_act, logic quit_evt);
    seq_out_t o;
    o.svc  = (nxt == PH_REQ);
    o.dnum = (nxt == PH_XFER);
    o.onl  = (nxt == PH_XFER) && done_act;
    o.quit = quit_evt;
    return o;
  endfunction

  // Rising edge of a synchronized active-high level.
  function automatic logic rise_of(logic now_v, logic prev_v);
    return now_v && !prev_v;
  endfunction

endpackage

// File: rtl/dev_xfer_sync.sv
module dev_xfer_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3,
  parameter logic [WIDTH-1:0] IDLE_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{IDLE_VAL}};
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dev_xfer_quit_timer.sv
module dev_xfer_quit_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  function automatic logic at_last(logic [CNT_W-1:0] c);
    return c == LAST;
  endfunction

  assign expire = run && at_last(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || expire) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dev_xfer_fsm.sv
module dev_xfer_fsm
  import dev_xfer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_s,
  input  logic strb_s,
  input  logic done_s,
  input  logic expire,
  output logic svc_q,
  output logic dnum_q,
  output logic onl_q,
  output logic quit_q,
  output logic in_idle,
  output logic in_xfer,
  output logic ack_evt
);
  phase_e   st, nxt;
  logic     ack_prev;
  logic     quit_evt;
  seq_out_t out_n;

  assign ack_evt = rise_of(ack_s, ack_prev);
  assign in_idle = (st == PH_IDLE);
  assign in_xfer = (st == PH_XFER);

  always_comb begin
    nxt      = st;
    quit_evt = 1'b0;
    unique case (st)
      PH_IDLE: if (ack_evt) nxt = PH_REQ;
      PH_REQ: begin
        if (strb_s)      nxt = PH_XFER;
        else if (!ack_s) nxt = PH_IDLE;
      end
      PH_XFER: begin
        if (!strb_s) nxt = PH_IDLE;
        else if (expire) begin
          nxt      = PH_IDLE;
          quit_evt = 1'b1;
        end
      end
      default: nxt = PH_IDLE;
    endcase
  end

  assign out_n = outputs_for(nxt, done_s, quit_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PH_IDLE;
      ack_prev <= 1'b0;
      svc_q    <= 1'b0;
      dnum_q   <= 1'b0;
      onl_q    <= 1'b0;
      quit_q   <= 1'b0;
    end else begin
      st       <= nxt;
      ack_prev <= ack_s;
      svc_q    <= out_n.svc;
      dnum_q   <= out_n.dnum;
      onl_q    <= out_n.onl;
      quit_q   <= out_n.quit;
    end
  end
endmodule

// File: rtl/dev_xfer_sequencer.sv
module dev_xfer_sequencer #(
  parameter int SYNC_STAGES = 2,
  parameter int QUIT_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_ack_n,
  input  logic num_strobe_n,
  input  logic xfer_done_n,
  output logic svc_req,
  output logic devnum_valid,
  output logic online,
  output logic quit_timeout
);
  localparam int NIN = 3;

  logic [NIN-1:0] raw_n, syn_n;
  logic ack_s, strb_s, done_s;
  logic in_idle, in_xfer, ack_evt, xfer_expire;

  assign raw_n = {sel_ack_n, num_strobe_n, xfer_done_n};

  dev_xfer_sync #(.STAGES(SYNC_STAGES), .WIDTH(NIN), .IDLE_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_n), .q(syn_n)
  );

  assign ack_s  = !syn_n[2];
  assign strb_s = !syn_n[1];
  assign done_s = !syn_n[0];

  dev_xfer_quit_timer #(.LIMIT(QUIT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(in_xfer), .expire(xfer_expire)
  );

  dev_xfer_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ack_s(ack_s), .strb_s(strb_s), .done_s(done_s), .expire(xfer_expire),
    .svc_q(svc_req), .dnum_q(devnum_valid), .onl_q(online), .quit_q(quit_timeout),
    .in_idle(in_idle), .in_xfer(in_xfer), .ack_evt(ack_evt)
  );
endmodule

// File: rtl/dev_xfer_sequencer_chk.sv
module dev_xfer_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic svc_req,
  input logic devnum_valid,
  input logic online,
  input logic quit_timeout,
  input logic in_idle,
  input logic ack_evt
);
  // R4
  online_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    online |-> devnum_valid);

  // R6
  quit_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quit_timeout |=> !quit_timeout);

  // R6
  quit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quit_timeout |-> !(svc_req || devnum_valid || online));

  // R3
  dnum_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devnum_valid) |-> $past(svc_req));

  // R2
  req_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_req) |-> $past(in_idle));

  // R8
  busy_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && !in_idle) |=> !svc_req);

  // R3
  outputs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({svc_req, devnum_valid, quit_timeout}));
endmodule

bind dev_xfer_sequencer dev_xfer_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .svc_req(svc_req), .devnum_valid(devnum_valid), .online(online),
  .quit_timeout(quit_timeout), .in_idle(in_idle), .ack_evt(ack_evt)
);

// File: tb/dev_xfer_sequencer_test.sv
module dev_xfer_sequencer_test;
  localparam int S = 2;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_ack_n = 1'b1, num_strobe_n = 1'b1, xfer_done_n = 1'b1;
  logic svc_req, devnum_valid, online, quit_timeout;

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dev_xfer_sequencer #(.SYNC_STAGES(S), .QUIT_CYCLES(Q)) uut (
    .clk(clk), .rst_n(rst_n), .sel_ack_n(sel_ack_n), .num_strobe_n(num_strobe_n),
    .xfer_done_n(xfer_done_n), .svc_req(svc_req), .devnum_valid(devnum_valid),
    .online(online), .quit_timeout(quit_timeout)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: history of active-high inputs, phase as integer.
  logic [2:0] hist[$];
  int  m_phase = 0;   // 0 idle, 1 request, 2 strobe phase
  int  m_len   = 0;   // clocks spent in strobe phase
  bit  m_svc = 0, m_dnum = 0, m_onl = 0, m_quit = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i < S + 3; i++) hist.push_back(3'b000);
      m_phase = 0; m_len = 0;
      m_svc = 0; m_dnum = 0; m_onl = 0; m_quit = 0;
    end else begin
      logic [2:0] cur, prv;
      hist.push_back({~sel_ack_n, ~num_strobe_n, ~xfer_done_n});
      if (hist.size() > S + 3) void'(hist.pop_front());
      cur = hist[hist.size() - 1 - S];
      prv = hist[hist.size() - 2 - S];
      m_quit = 0;
      if (m_phase == 0) begin
        if (cur[2] && !prv[2]) m_phase = 1;
      end else if (m_phase == 1) begin
        if (cur[1]) begin m_phase = 2; m_len = 0; end
        else if (!cur[2]) m_phase = 0;
      end else begin
        m_len++;
        if (!cur[1]) m_phase = 0;
        else if (m_len == Q) begin m_phase = 0; m_quit = 1; end
      end
      m_svc  = (m_phase == 1);
      m_dnum = (m_phase == 2);
      m_onl  = (m_phase == 2) && cur[0];
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      chk("R2 svc_req model", int'(svc_req), int'(m_svc));
      chk("R3 devnum_valid model", int'(devnum_valid), int'(m_dnum));
      chk("R4 online model", int'(online), int'(m_onl));
      chk("R6 quit_timeout model", int'(quit_timeout), int'(m_quit));
    end
  end

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_dnum();
    for (int i = 0; i < 50 && !devnum_valid; i++) @(negedge clk);
  endtask

  initial begin
    wn(3);
    chk("R9 svc in reset", int'(svc_req), 0);
    chk("R9 dnum in reset", int'(devnum_valid), 0);
    chk("R9 online in reset", int'(online), 0);
    chk("R9 quit in reset", int'(quit_timeout), 0);
    rst_n = 1'b1;
    wn(3);

    // Normal transfer with latency measurement
    sel_ack_n = 1'b0;
    wn(S);
    chk("R1 svc not yet", int'(svc_req), 0);
    wn(1);
    chk("R1 svc latency", int'(svc_req), 1);
    chk("R2 request phase", int'(svc_req), 1);
    num_strobe_n = 1'b0;
    wn(S + 1);
    chk("R3 dnum on strobe", int'(devnum_valid), 1);
    chk("R3 svc dropped", int'(svc_req), 0);
    xfer_done_n = 1'b0;
    wn(S + 1);
    chk("R4 online with done", int'(online), 1);
    xfer_done_n = 1'b1;
    wn(S + 1);
    chk("R4 online removed", int'(online), 0);
    chk("R4 still strobe phase", int'(devnum_valid), 1);
    num_strobe_n = 1'b1;
    wn(S + 1);
    chk("R5 idle after release", int'(devnum_valid), 0);
    wn(4);
    chk("R8 held ack no restart", int'(svc_req), 0);
    sel_ack_n = 1'b1;
    wn(4);

    // Done and strobe while idle
    xfer_done_n = 1'b0;
    wn(6);
    chk("R4 done ignored idle", int'(online), 0);
    xfer_done_n = 1'b1;
    num_strobe_n = 1'b0;
    wn(6);
    chk("R8 strobe ignored idle", int'(devnum_valid), 0);
    num_strobe_n = 1'b1;
    wn(4);

    // Abort before strobe
    sel_ack_n = 1'b0;
    wn(S + 1);
    chk("R7 request raised", int'(svc_req), 1);
    sel_ack_n = 1'b1;
    wn(S + 1);
    chk("R7 request withdrawn", int'(svc_req), 0);
    chk("R7 no strobe phase", int'(devnum_valid), 0);
    wn(3);

    // New acknowledge edge while busy
    sel_ack_n = 1'b0;
    wn(S + 1);
    num_strobe_n = 1'b0;
    wn(S + 1);
    sel_ack_n = 1'b1;
    wn(S + 1);
    sel_ack_n = 1'b0;
    wn(S + 1);
    chk("R8 busy ack dnum held", int'(devnum_valid), 1);
    chk("R8 busy ack no svc", int'(svc_req), 0);
    num_strobe_n = 1'b1;
    wn(S + 1);
    chk("R8 idle after busy", int'(devnum_valid), 0);
    sel_ack_n = 1'b1;
    wn(4);

    // Timeout of a held strobe
    sel_ack_n = 1'b0;
    wn(S + 1);
    num_strobe_n = 1'b0;
    wait_dnum();
    begin
      int len = 0;
      while (devnum_valid && len < 100) begin
        len++;
        @(negedge clk);
      end
      chk("R6 strobe phase length", len, Q);
    end
    chk("R6 quit pulse", int'(quit_timeout), 1);
    wn(1);
    chk("R6 quit one clock", int'(quit_timeout), 0);
    wn(8);
    chk("R6 idle after quit svc", int'(svc_req), 0);
    chk("R6 idle after quit dnum", int'(devnum_valid), 0);
    num_strobe_n = 1'b1;
    sel_ack_n = 1'b1;
    wn(4);

    // Short phase, then a fresh full window
    sel_ack_n = 1'b0;
    wn(S + 1);
    num_strobe_n = 1'b0;
    wait_dnum();
    wn(5);
    num_strobe_n = 1'b1;
    sel_ack_n = 1'b1;
    wn(S + 3);
    sel_ack_n = 1'b0;
    wn(S + 1);
    num_strobe_n = 1'b0;
    wait_dnum();
    begin
      int len = 0;
      while (devnum_valid && len < 100) begin
        len++;
        @(negedge clk);
      end
      chk("R5 fresh window length", len, Q);
    end
    num_strobe_n = 1'b1;
    sel_ack_n = 1'b1;
    wn(4);

    // Release seen in the last clock of the window
    sel_ack_n = 1'b0;
    wn(S + 1);
    num_strobe_n = 1'b0;
    wait_dnum();
    wn(Q - S - 1);
    num_strobe_n = 1'b1;
    begin
      int pulses = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (quit_timeout) pulses++;
      end
      chk("R6 release beats timeout", pulses, 0);
    end
    chk("R5 idle after late release", int'(devnum_valid), 0);
    sel_ack_n = 1'b1;
    wn(4);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog R6: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule